// File: doc/BRIEF.md
# Segmented Base-Limit Address Translator

The translator turns a 14-bit virtual address into a 16-bit physical address. The two top address bits pick one of four segment slots, and the twelve low bits give an offset into that segment. Three slots (code, heap and stack) hold a base, a limit and a set of access rights. The fourth slot has no registers, and any access to it faults. A valid offset is added to the segment base. An offset at or beyond the limit, or an access the rights do not allow, produces a fault code and no address.

Software, or a controller next to the block, loads each segment through a single-cycle register write port. Accesses arrive on a request port that carries a valid flag, the address and the access kind. One cycle later the response port returns either the physical address or a fault code. Any number of requests may be issued back to back.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is address bits [13:12] and the offset is bits [11:0].
- R2: If the offset is greater than or equal to the segment's 13-bit limit, the response carries fault code 1 (limit) and a physical address of 0.
- R3: Otherwise, when the access is allowed, the fault code is 0 and the physical address is (base + offset) modulo 2^16.
- R4: Rights bit 0 permits read, bit 1 permits write and bit 2 permits execute. Access code 0 is a read, 1 a write, 2 an instruction fetch, and 3 is never permitted. A denied access returns fault code 2 and address 0.
- R5: Segment 3 is unmapped. Every access to it returns fault code 3 and address 0. A register write aimed at segment 3 changes no segment.
- R6: Fault priority is unmapped, then limit, then rights.
- R7: The response valid flag follows the request valid flag by exactly one cycle. While the response is not valid, the address and fault outputs are 0.
- R8: After reset every segment has base 0, limit 0 and no rights, and all response outputs are 0.
- R9: A register write takes effect for requests issued from the next cycle onward. A request issued in the same cycle as a write sees the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Segment register write strobe |
| cfg_seg_i | input | 2 | Segment number to write |
| cfg_base_i | input | 16 | New base |
| cfg_limit_i | input | 13 | New limit (segment size in bytes) |
| cfg_rights_i | input | 3 | New rights: bit0 read, bit1 write, bit2 execute |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 14 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | 16 | Physical address, 0 on a fault |
| rsp_fault_o | output | 2 | 0 none, 1 limit, 2 rights, 3 unmapped |

## Verification
The assertions assume that the request valid flag is low while reset is held, so the first response after reset is a well-defined idle. They also assume that the address and access inputs are known whenever valid is high. The bench drives every input on the falling edge, keeps valid low through reset, and always drives defined values, including the reserved access code. A per-segment model in the bench predicts each response, and that includes the case where a register write and a request land in the same cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_RIGHTS = 2'd2,
    FLT_UNMAP  = 2'd3
  } fault_e;

  localparam int unsigned RIGHT_R = 0;
  localparam int unsigned RIGHT_W = 1;
  localparam int unsigned RIGHT_X = 2;
  localparam int unsigned RIGHTS_W = 3;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W    = 2,
  parameter int unsigned N_MAPPED = 3,
  parameter int unsigned BASE_W   = 16,
  parameter int unsigned LIM_W    = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SEG_W-1:0]    wseg_i,
  input  logic [BASE_W-1:0]   wbase_i,
  input  logic [LIM_W-1:0]    wlimit_i,
  input  logic [RIGHTS_W-1:0] wrights_i,
  input  logic [SEG_W-1:0]    rseg_i,
  output logic                rmapped_o,
  output logic [BASE_W-1:0]   rbase_o,
  output logic [LIM_W-1:0]    rlimit_o,
  output logic [RIGHTS_W-1:0] rrights_o
);
  logic [BASE_W-1:0]   base_q   [N_MAPPED];
  logic [LIM_W-1:0]    limit_q  [N_MAPPED];
  logic [RIGHTS_W-1:0] rights_q [N_MAPPED];

  for (genvar g = 0; g < N_MAPPED; g++) begin : g_seg
    logic hit;
    assign hit = we_i && (wseg_i == SEG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]   <= '0;
        limit_q[g]  <= '0;
        rights_q[g] <= '0;
      end else if (hit) begin
        base_q[g]   <= wbase_i;
        limit_q[g]  <= wlimit_i;
        rights_q[g] <= wrights_i;
      end
    end

    // R5 / R9: only a write addressed to this slot may change it
    a_r5_slot_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && wseg_i == SEG_W'(g)) |=> ($stable(base_q[g]) && $stable(limit_q[g])
                                          && $stable(rights_q[g])));
  end

  always_comb begin
    rmapped_o = 1'b0;
    rbase_o   = '0;
    rlimit_o  = '0;
    rrights_o = '0;
    for (int i = 0; i < N_MAPPED; i++) begin
      if (rseg_i == SEG_W'(i)) begin
        rmapped_o = 1'b1;
        rbase_o   = base_q[i];
        rlimit_o  = limit_q[i];
        rrights_o = rights_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned BASE_W = 16,
  parameter int unsigned LIM_W  = 13
) (
  input  logic                mapped_i,
  input  logic [BASE_W-1:0]   base_i,
  input  logic [LIM_W-1:0]    limit_i,
  input  logic [RIGHTS_W-1:0] rights_i,
  input  logic [OFF_W-1:0]    offset_i,
  input  acc_e                acc_i,
  output fault_e              fault_o,
  output logic [BASE_W-1:0]   paddr_o
);
  logic over_limit;
  logic allowed;

  assign over_limit = {{(LIM_W-OFF_W){1'b0}}, offset_i} >= limit_i;

  always_comb begin
    unique case (acc_i)
      ACC_READ:  allowed = rights_i[RIGHT_R];
      ACC_WRITE: allowed = rights_i[RIGHT_W];
      ACC_FETCH: allowed = rights_i[RIGHT_X];
      default:   allowed = 1'b0;
    endcase
  end

  // priority: unmapped, limit, rights
  always_comb begin
    paddr_o = '0;
    if (!mapped_i)        fault_o = FLT_UNMAP;
    else if (over_limit)  fault_o = FLT_LIMIT;
    else if (!allowed)    fault_o = FLT_RIGHTS;
    else begin
      fault_o = FLT_NONE;
      paddr_o = base_i + {{(BASE_W-OFF_W){1'b0}}, offset_i};
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W     = 14,
  parameter int unsigned SEG_W    = 2,
  parameter int unsigned N_MAPPED = 3,
  parameter int unsigned BASE_W   = 16,
  localparam int unsigned OFF_W   = VA_W - SEG_W,
  localparam int unsigned LIM_W   = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEG_W-1:0]  cfg_seg_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [LIM_W-1:0]  cfg_limit_i,
  input  logic [2:0]        cfg_rights_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_addr_i,
  input  logic [1:0]        req_acc_i,
  output logic              rsp_valid_o,
  output logic [BASE_W-1:0] rsp_paddr_o,
  output logic [1:0]        rsp_fault_o
);
  logic [SEG_W-1:0]    seg;
  logic [OFF_W-1:0]    offset;
  logic                rd_mapped;
  logic [BASE_W-1:0]   rd_base;
  logic [LIM_W-1:0]    rd_limit;
  logic [RIGHTS_W-1:0] rd_rights;
  fault_e              chk_fault;
  logic [BASE_W-1:0]   chk_paddr;

  assign seg    = req_addr_i[VA_W-1 -: SEG_W];
  assign offset = req_addr_i[OFF_W-1:0];

  seg_regfile #(
    .SEG_W(SEG_W), .N_MAPPED(N_MAPPED), .BASE_W(BASE_W), .LIM_W(LIM_W)
  ) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wseg_i    (cfg_seg_i),
    .wbase_i   (cfg_base_i),
    .wlimit_i  (cfg_limit_i),
    .wrights_i (cfg_rights_i),
    .rseg_i    (seg),
    .rmapped_o (rd_mapped),
    .rbase_o   (rd_base),
    .rlimit_o  (rd_limit),
    .rrights_o (rd_rights)
  );

  seg_check #(
    .OFF_W(OFF_W), .BASE_W(BASE_W), .LIM_W(LIM_W)
  ) i_check (
    .mapped_i (rd_mapped),
    .base_i   (rd_base),
    .limit_i  (rd_limit),
    .rights_i (rd_rights),
    .offset_i (offset),
    .acc_i    (acc_e'(req_acc_i)),
    .fault_o  (chk_fault),
    .paddr_o  (chk_paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= FLT_NONE;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_paddr_o <= req_valid_i ? chk_paddr : '0;
      rsp_fault_o <= req_valid_i ? chk_fault : FLT_NONE;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r7_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_paddr_o == '0 && rsp_fault_o == FLT_NONE));
  a_r2_fault_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o != FLT_NONE |-> rsp_paddr_o == '0);
  a_r5_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && seg >= SEG_W'(N_MAPPED)) |=> rsp_fault_o == FLT_UNMAP);
  a_r2_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rd_mapped && {1'b0, offset} >= rd_limit) |=> rsp_fault_o == FLT_LIMIT);
endmodule

// File: tb/test_seg_xlate.sv
`timescale 1ns/100ps
module test_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_seg = '0;
  logic [15:0] cfg_base = '0;
  logic [12:0] cfg_limit = '0;
  logic [2:0]  cfg_rights = '0;
  logic        req_valid = 1'b0;
  logic [13:0] req_addr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int failures = 0;

  logic [15:0] m_base [3];
  logic [12:0] m_lim  [3];
  logic [2:0]  m_rt   [3];

  always #2.5 clk = ~clk;

  seg_xlate i_seg_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_seg_i(cfg_seg), .cfg_base_i(cfg_base),
    .cfg_limit_i(cfg_limit), .cfg_rights_i(cfg_rights),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic void model(input logic [13:0] a, input logic [1:0] acc,
                                output logic [15:0] pa, output logic [1:0] f);
    int s;
    logic [11:0] off;
    s = int'(a[13:12]);
    off = a[11:0];
    pa = '0;
    if (s == 3) f = 2'd3;
    else if ({1'b0, off} >= m_lim[s]) f = 2'd1;
    else if (acc == 2'd3 || !m_rt[s][acc]) f = 2'd2;
    else begin
      f = 2'd0;
      pa = m_base[s] + {4'h0, off};
    end
  endfunction

  task automatic cfg(input logic [1:0] s, input logic [15:0] b,
                     input logic [12:0] l, input logic [2:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = s; cfg_base = b; cfg_limit = l; cfg_rights = r;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s != 2'd3) begin
      m_base[s] = b; m_lim[s] = l; m_rt[s] = r;
    end
  endtask

  task automatic xlate(input string rq, input logic [13:0] a, input logic [1:0] acc);
    logic [15:0] pa;
    logic [1:0] f;
    model(a, acc, pa, f);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, "valid", int'(rsp_valid), 1);
    check(rq, "fault", int'(rsp_fault), int'(f));
    check(rq, "paddr", int'(rsp_paddr), int'(pa));
  endtask

  task automatic t_reset;
    check("R8", "valid after reset", int'(rsp_valid), 0);
    check("R8", "paddr after reset", int'(rsp_paddr), 0);
    check("R8", "fault after reset", int'(rsp_fault), 0);
    // limit 0 after reset: every mapped access is a limit fault
    xlate("R8", 14'h0000, 2'd0);
    xlate("R8", 14'h1000, 2'd1);
    @(negedge clk);
    check("R7", "idle valid", int'(rsp_valid), 0);
    check("R7", "idle paddr", int'(rsp_paddr), 0);
  endtask

  task automatic t_basic;
    cfg(2'd0, 16'h8000, 13'd2048, 3'b101);  // code: R,X
    cfg(2'd1, 16'h2000, 13'd256,  3'b011);  // heap: R,W
    cfg(2'd2, 16'hFF00, 13'd4096, 3'b011);  // stack: R,W
    xlate("R1", 14'h0010, 2'd0);
    xlate("R3", 14'h0123, 2'd2);
    xlate("R3", 14'h1055, 2'd1);
    xlate("R1", 14'h2004, 2'd0);
  endtask

  task automatic t_limit;
    xlate("R2", 14'h10FF, 2'd0);   // last valid heap byte
    xlate("R2", 14'h1100, 2'd0);   // offset == limit
    xlate("R2", 14'h1FFF, 2'd1);
    xlate("R2", 14'h3FFF & 14'h2FFF, 2'd0); // full 4 KiB stack, top byte
  endtask

  task automatic t_wrap;
    xlate("R3", 14'h2200, 2'd1);   // 0xFF00 + 0x200 wraps to 0x0100
    check("R3", "wrap value", int'(rsp_paddr), 16'h0100);
  endtask

  task automatic t_rights;
    xlate("R4", 14'h0020, 2'd1);   // write to code
    xlate("R4", 14'h1020, 2'd2);   // fetch from heap
    xlate("R4", 14'h1020, 2'd3);   // reserved access code
    xlate("R4", 14'h0020, 2'd3);
    cfg(2'd1, 16'h2000, 13'd256, 3'b000);
    xlate("R4", 14'h1000, 2'd0);
  endtask

  task automatic t_unmapped;
    xlate("R5", 14'h3000, 2'd0);
    xlate("R5", 14'h3FFF, 2'd2);
    cfg(2'd3, 16'h1234, 13'd4096, 3'b111);
    xlate("R5", 14'h3001, 2'd0);
    xlate("R5", 14'h0040, 2'd0);   // other slots unchanged
    xlate("R5", 14'h2040, 2'd1);
  endtask

  task automatic t_priority;
    // heap limit 256, no rights: offset past limit gives limit, not rights
    xlate("R6", 14'h1300, 2'd2);
    // code: write inside limit gives rights fault
    xlate("R6", 14'h0001, 2'd1);
    // beyond limit with denied access: limit wins
    xlate("R6", 14'h0900, 2'd1);
  endtask

  task automatic t_same_cycle;
    logic [15:0] pa;
    logic [1:0] f;
    model(14'h1010, 2'd0, pa, f);  // old heap: no rights
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 2'd1; cfg_base = 16'h4000; cfg_limit = 13'd512; cfg_rights = 3'b001;
    req_valid = 1'b1; req_addr = 14'h1010; req_acc = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    m_base[1] = 16'h4000; m_lim[1] = 13'd512; m_rt[1] = 3'b001;
    check("R9", "same-cycle fault", int'(rsp_fault), int'(f));
    check("R9", "same-cycle paddr", int'(rsp_paddr), int'(pa));
    xlate("R9", 14'h1010, 2'd0);
    check("R9", "new base used", int'(rsp_paddr), 16'h4010);
  endtask

  task automatic t_back_to_back;
    logic [15:0] pa0, pa1, pa2;
    logic [1:0] f0, f1, f2;
    model(14'h0100, 2'd2, pa0, f0);
    model(14'h3000, 2'd0, pa1, f1);
    model(14'h11F0, 2'd0, pa2, f2);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 14'h0100; req_acc = 2'd2;
    @(negedge clk);
    check("R7", "b2b valid0", int'(rsp_valid), 1);
    check("R7", "b2b paddr0", int'(rsp_paddr), int'(pa0));
    req_addr = 14'h3000; req_acc = 2'd0;
    @(negedge clk);
    check("R7", "b2b fault1", int'(rsp_fault), int'(f1));
    req_addr = 14'h11F0; req_acc = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7", "b2b paddr2", int'(rsp_paddr), int'(pa2));
    check("R7", "b2b fault2", int'(rsp_fault), int'(f2));
    @(negedge clk);
    check("R7", "b2b idle", int'(rsp_valid), 0);
    check("R7", "b2b idle fault", int'(rsp_fault), int'(f0 & 2'd0));
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_rt[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_limit();
    t_wrap();
    t_rights();
    t_unmapped();
    t_priority();
    t_same_cycle();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule